// File: doc/BRIEF.md
# Backlight PWM Divider Selection Engine

This block picks the settings for a backlight PWM generator that is clocked from a fixed 27 MHz reference. Given a requested PWM frequency in hertz, it returns an exponent Pn (the PWM counter runs over 2^Pn steps) and an 8-bit pre-divider F. The PWM frequency is then the reference divided by F·2^Pn. The engine favours duty-cycle resolution, so it looks for the largest Pn that still lets the total divide ratio land close to the ideal one.

A request starts with a one-cycle strobe. It carries the frequency and the sink's lowest and highest supported exponents. The engine first forms the ideal ratio with a bit-serial restoring division. It then checks that the request can be met at all. After that it walks Pn downward one value per clock. When it finishes it raises a one-cycle done pulse, and the result stays on the outputs until the next accepted request. There are three outcomes besides a clean match. A zero frequency means the panel keeps its own default. An infeasible request is flagged as out of range. A search in which no exponent fits ends on the lowest exponent and is flagged.

Top module: `pwm_divsel`

## Requirements
- R1: While reset is asserted and after it is released, busy, done, skip, range_err and inexact are 0, and pn_out and div_out are 0.
- R2: For a nonzero freq_hz, the ideal ratio is r = floor(27000000 / freq_hz). The acceptance window is lo = floor(3r/4) to hi = floor(5r/4), both ends included.
- R3: A request with freq_hz = 0 produces done on the next cycle with skip = 1, range_err = 0, inexact = 0, pn_out = 0 and div_out = 0.
- R4: A request is rejected with done and range_err = 1, and with pn_out = 0 and div_out = 0, in any of three cases: lo < 2^Pmin, hi > 255·2^Pmax, or Pmin > Pmax.
- R5: Candidates are tried from Pmax downward to Pmin, with Pmin included. The first candidate whose product F·2^Pn lies inside the window is reported, with skip, range_err and inexact all 0.
- R6: For a candidate Pn, F is r/2^Pn rounded to nearest, with halves rounding up. F is then clamped to the range 1 to 255.
- R7: Only bits 4:0 of cap_min and cap_max are used, as Pmin and Pmax. The upper bits have no effect on the result.
- R8: If no candidate fits, the result is Pn = Pmin with the F computed for Pmin, and inexact = 1.
- R9: busy is 1 from the cycle after an accepted nonzero request until done is raised. done is a single-cycle pulse. A start that arrives while busy is 1 is ignored.
- R10: pn_out, div_out and the three flags keep their values from a done pulse until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, accepted only when not busy |
| freq_hz | input | 32 | Requested PWM frequency in Hz; 0 keeps the default |
| cap_min | input | 8 | Sink minimum exponent capability (bits 4:0 used) |
| cap_max | input | 8 | Sink maximum exponent capability (bits 4:0 used) |
| busy | output | 1 | Division or search in progress |
| done | output | 1 | One-cycle completion pulse |
| pn_out | output | 5 | Chosen exponent Pn |
| div_out | output | 8 | Chosen pre-divider F |
| skip | output | 1 | Zero frequency: default kept, no values produced |
| range_err | output | 1 | Request infeasible for the capability range |
| inexact | output | 1 | No candidate fitted; the Pmin fallback is reported |

## Verification
The vectors cover several kinds of request, and each one isolates a different part of the logic. Some match at the top exponent. One matches only at the lowest exponent, which catches a loop that stops one step early. In some the rounding and the truncating quotient give different F values, and one forces the clamp up to 1. Out-of-range rejections hit the low bound, the high bound and an inverted capability pair. Other directed vectors cover the fallback with no match, masking of the capability fields, a zero frequency, a start that arrives while busy, and holding of the result.

// File: rtl/pwmdiv_pkg.sv
package pwmdiv_pkg;
  // Field widths fixed by the sink's register format
  localparam int PN_W  = 5;
  localparam int DIV_W = 8;
  localparam int DIV_MAX = 255;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DIVIDE = 2'd1,
    ST_BOUND  = 2'd2,
    ST_SEARCH = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic [PN_W-1:0]  pn;
    logic [DIV_W-1:0] div;
    logic             skip;
    logic             range_err;
    logic             inexact;
  } result_t;
endpackage

// File: rtl/pwmdiv_divider.sv
module pwmdiv_divider #(
  parameter int unsigned DIVIDEND = 27_000_000,
  parameter int          DSR_W    = 32,
  parameter int          QW       = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [DSR_W-1:0] divisor,
  output logic             valid,
  output logic [QW-1:0]    quotient
);
  localparam int CW = $clog2(QW + 1);
  localparam logic [QW-1:0] DVD_INIT = QW'(DIVIDEND);

  logic             active_q, active_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic [QW-1:0]    dvd_q, dvd_n;
  logic [QW-1:0]    quo_q, quo_n;
  logic [DSR_W-1:0] rem_q, rem_n;
  logic [DSR_W-1:0] dsr_q, dsr_n;
  logic             valid_q, valid_n;

  logic [DSR_W:0] trial, diff;
  logic           ge;

  always_comb begin
    trial = {rem_q, dvd_q[QW-1]};
    diff  = trial - {1'b0, dsr_q};
    ge    = (trial >= {1'b0, dsr_q});
  end

  always_comb begin
    active_n = active_q;
    cnt_n    = cnt_q;
    dvd_n    = dvd_q;
    quo_n    = quo_q;
    rem_n    = rem_q;
    dsr_n    = dsr_q;
    valid_n  = 1'b0;
    if (go) begin
      active_n = 1'b1;
      cnt_n    = CW'(QW);
      dvd_n    = DVD_INIT;
      quo_n    = '0;
      rem_n    = '0;
      dsr_n    = divisor;
    end else if (active_q) begin
      rem_n = ge ? diff[DSR_W-1:0] : trial[DSR_W-1:0];
      quo_n = {quo_q[QW-2:0], ge};
      dvd_n = {dvd_q[QW-2:0], 1'b0};
      cnt_n = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        active_n = 1'b0;
        valid_n  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      dvd_q    <= '0;
      quo_q    <= '0;
      rem_q    <= '0;
      dsr_q    <= '0;
      valid_q  <= 1'b0;
    end else begin
      active_q <= active_n;
      cnt_q    <= cnt_n;
      dvd_q    <= dvd_n;
      quo_q    <= quo_n;
      rem_q    <= rem_n;
      dsr_q    <= dsr_n;
      valid_q  <= valid_n;
    end
  end

  assign valid    = valid_q;
  assign quotient = quo_q;

  // Partial remainder must stay below the divisor during iteration
  assert_rem_below_R2: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (rem_q < dsr_q));
  // Iteration counter never runs out while active
  assert_cnt_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q != '0));
endmodule

// File: rtl/pwmdiv_window.sv
module pwmdiv_window #(
  parameter int QW   = 25,
  parameter int PW   = 40,
  parameter int PN_W = 5
) (
  input  logic [QW-1:0]   ratio,
  input  logic [PN_W-1:0] pn_min,
  input  logic [PN_W-1:0] pn_max,
  output logic [PW-1:0]   lo,
  output logic [PW-1:0]   hi,
  output logic            bad
);
  logic [PW-1:0] r_ext, floor_lim, ceil_lim;

  always_comb begin
    r_ext     = PW'(ratio);
    lo        = (r_ext * PW'(3)) >> 2;
    hi        = (r_ext * PW'(5)) >> 2;
    floor_lim = PW'(1) << pn_min;
    ceil_lim  = PW'(255) << pn_max;
    bad       = (lo < floor_lim) || (hi > ceil_lim) || (pn_min > pn_max);
  end
endmodule

// File: rtl/pwmdiv_candidate.sv
module pwmdiv_candidate #(
  parameter int QW    = 25,
  parameter int PW    = 40,
  parameter int PN_W  = 5,
  parameter int DIV_W = 8
) (
  input  logic [QW-1:0]    ratio,
  input  logic [PN_W-1:0]  pn,
  input  logic [PW-1:0]    lo,
  input  logic [PW-1:0]    hi,
  output logic [DIV_W-1:0] f,
  output logic             hit
);
  localparam logic [PW-1:0] FMAX = PW'((1 << DIV_W) - 1);

  logic [PW-1:0] half, q, prod;

  always_comb begin
    half = (pn == '0) ? '0 : (PW'(1) << (pn - 1'b1));
    q    = (PW'(ratio) + half) >> pn;
    if (q == '0)
      f = DIV_W'(1);
    else if (q > FMAX)
      f = FMAX[DIV_W-1:0];
    else
      f = q[DIV_W-1:0];
    prod = PW'(f) << pn;
    hit  = (prod >= lo) && (prod <= hi);
  end
endmodule

// File: rtl/pwm_divsel.sv
module pwm_divsel
  import pwmdiv_pkg::*;
#(
  parameter int unsigned BASE_HZ = 27_000_000,
  parameter int          FREQ_W  = 32,
  parameter int          CAP_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FREQ_W-1:0] freq_hz,
  input  logic [CAP_W-1:0]  cap_min,
  input  logic [CAP_W-1:0]  cap_max,
  output logic              busy,
  output logic              done,
  output logic [PN_W-1:0]   pn_out,
  output logic [DIV_W-1:0]  div_out,
  output logic              skip,
  output logic              range_err,
  output logic              inexact
);
  localparam int QW = $clog2(BASE_HZ + 1);
  localparam int PW = DIV_W + (1 << PN_W);

  seq_state_t      st_q, st_n;
  logic [PN_W-1:0] pmin_q, pmin_n, pmax_q, pmax_n, pn_q, pn_n;
  logic [QW-1:0]   ratio_q, ratio_n;
  result_t         res_q, res_n;
  logic            done_q, done_n;

  logic             accept, div_go, div_valid;
  logic [QW-1:0]    div_quot;
  logic [PW-1:0]    win_lo, win_hi;
  logic             win_bad, cand_hit;
  logic [DIV_W-1:0] cand_f;

  assign accept = start && (st_q == ST_IDLE);
  assign div_go = accept && (freq_hz != '0);

  pwmdiv_divider #(.DIVIDEND(BASE_HZ), .DSR_W(FREQ_W), .QW(QW)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .divisor(freq_hz),
    .valid(div_valid), .quotient(div_quot)
  );

  pwmdiv_window #(.QW(QW), .PW(PW), .PN_W(PN_W)) u_win (
    .ratio(ratio_q), .pn_min(pmin_q), .pn_max(pmax_q),
    .lo(win_lo), .hi(win_hi), .bad(win_bad)
  );

  pwmdiv_candidate #(.QW(QW), .PW(PW), .PN_W(PN_W), .DIV_W(DIV_W)) u_cand (
    .ratio(ratio_q), .pn(pn_q), .lo(win_lo), .hi(win_hi),
    .f(cand_f), .hit(cand_hit)
  );

  always_comb begin
    st_n    = st_q;
    pmin_n  = pmin_q;
    pmax_n  = pmax_q;
    pn_n    = pn_q;
    ratio_n = ratio_q;
    res_n   = res_q;
    done_n  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          pmin_n = cap_min[PN_W-1:0];
          pmax_n = cap_max[PN_W-1:0];
          res_n  = '0;
          if (freq_hz == '0) begin
            res_n.skip = 1'b1;
            done_n     = 1'b1;
          end else begin
            st_n = ST_DIVIDE;
          end
        end
      end
      ST_DIVIDE: begin
        if (div_valid) begin
          ratio_n = div_quot;
          st_n    = ST_BOUND;
        end
      end
      ST_BOUND: begin
        if (win_bad) begin
          res_n.range_err = 1'b1;
          done_n          = 1'b1;
          st_n            = ST_IDLE;
        end else begin
          pn_n = pmax_q;
          st_n = ST_SEARCH;
        end
      end
      ST_SEARCH: begin
        if (cand_hit || (pn_q == pmin_q)) begin
          res_n.pn      = pn_q;
          res_n.div     = cand_f;
          res_n.inexact = !cand_hit;
          done_n        = 1'b1;
          st_n          = ST_IDLE;
        end else begin
          pn_n = pn_q - 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      pmin_q  <= '0;
      pmax_q  <= '0;
      pn_q    <= '0;
      ratio_q <= '0;
      res_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      pmin_q  <= pmin_n;
      pmax_q  <= pmax_n;
      pn_q    <= pn_n;
      ratio_q <= ratio_n;
      res_q   <= res_n;
      done_q  <= done_n;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign pn_out    = res_q.pn;
  assign div_out   = res_q.div;
  assign skip      = res_q.skip;
  assign range_err = res_q.range_err;
  assign inexact   = res_q.inexact;

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_flag_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot0({skip, range_err, inexact}));
  assert_div_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !skip && !range_err) |-> (div_out != '0));
  assert_search_bounds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SEARCH) |-> ((pn_q >= pmin_q) && (pn_q <= pmax_q)));
  assert_fallback_min_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && inexact) |-> (pn_out == pmin_q));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(pn_out) && $stable(div_out) && $stable(inexact)));
  assert_idle_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/pwm_divsel_test.sv
module pwm_divsel_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] freq_hz;
  logic [7:0]  cap_min, cap_max;
  logic        busy, done, skip, range_err, inexact;
  logic [4:0]  pn_out;
  logic [7:0]  div_out;

  int total = 0;
  int bad = 0;
  bit hung = 0;

  always #10 clk = ~clk;

  pwm_divsel uut (
    .clk(clk), .rst_n(rst_n), .start(start), .freq_hz(freq_hz),
    .cap_min(cap_min), .cap_max(cap_max), .busy(busy), .done(done),
    .pn_out(pn_out), .div_out(div_out), .skip(skip),
    .range_err(range_err), .inexact(inexact)
  );

  // Outcome kinds: 0 match, 1 inexact, 2 range error, 3 skip
  localparam int N = 13;
  localparam int unsigned V_FREQ [N] = '{200, 1000, 20000, 4500000, 4500000,
    100000, 10, 27000000, 1000, 0, 4500000, 1, 1};
  localparam int V_CMIN [N] = '{0, 0, 2, 1, 2, 10, 0, 0, 12, 0, 8'hE1, 0, 0};
  localparam int V_CMAX [N] = '{16, 15, 8, 3, 4, 12, 4, 8, 10, 16, 8'h23, 31, 18};
  localparam int V_KIND [N] = '{0, 0, 0, 0, 1, 2, 2, 2, 2, 3, 0, 0, 0};
  localparam int V_PN   [N] = '{16, 15, 8, 1, 2, 0, 0, 0, 0, 0, 1, 25, 18};
  localparam int V_DIV  [N] = '{2, 1, 5, 3, 2, 0, 0, 0, 0, 0, 3, 1, 103};
  localparam string V_TAG [N] = '{"R2 R5", "R5", "R6", "R5", "R8 R6", "R4",
    "R4", "R4", "R4", "R3", "R7", "R5 R6", "R6"};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start(input int unsigned f, input int cmin, input int cmax);
    @(negedge clk);
    freq_hz = f; cap_min = 8'(cmin); cap_max = 8'(cmax); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int guard = 0;
    while (!done && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    total++;
    if (!done) begin
      bad++;
      $display("FAIL %s actual=no_done expected=done", tag);
    end
  endtask

  task automatic check_result(input string tag, input int kind, input int pn, input int dv);
    check({tag, " skip"},    32'(skip),      32'(kind == 3));
    check({tag, " range"},   32'(range_err), 32'(kind == 2));
    check({tag, " inexact"}, 32'(inexact),   32'(kind == 1));
    check({tag, " pn"},      32'(pn_out),    32'(pn));
    check({tag, " div"},     32'(div_out),   32'(dv));
  endtask

  initial begin
    #3_000_000;
    hung = 1;
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; freq_hz = '0; cap_min = '0; cap_max = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 busy", 32'(busy), 0);
    check("R1 done", 32'(done), 0);
    check_result("R1", 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after release", 32'(busy), 0);

    for (int i = 0; i < N; i++) begin
      pulse_start(V_FREQ[i], V_CMIN[i], V_CMAX[i]);
      wait_done(V_TAG[i]);
      check_result(V_TAG[i], V_KIND[i], V_PN[i], V_DIV[i]);
      @(negedge clk);
      check({V_TAG[i], " R9 single pulse"}, 32'(done), 0);
    end

    // R9: busy during work, start while busy ignored
    pulse_start(200, 0, 16);
    check("R9 busy", 32'(busy), 1);
    pulse_start(1000, 0, 15);
    wait_done("R9 ignore");
    check_result("R9 ignore", 0, 16, 2);
    check("R9 idle at done", 32'(busy), 0);

    // R10: result held while idle
    repeat (6) @(negedge clk);
    check_result("R10 hold", 0, 16, 2);

    // R3: zero frequency after a real result clears values
    pulse_start(0, 0, 16);
    check("R3 done next", 32'(done), 1);
    check_result("R3 clear", 3, 0, 0);

    // R1: reset in mid-operation
    pulse_start(1, 0, 31);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid reset busy", 32'(busy), 0);
    check_result("R1 mid reset", 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);

    if (!hung) begin
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule